// File: doc/BRIEF.md
# Receive-Inhibit Status Flag Controller

This block holds the status flags of a token-passing network node. The receiver locks itself out after every packet it stores. It stays locked until software issues an enable-receive command naming a buffer page. While the lock is on, every packet addressed to the node is refused with a NAK. A separate power-on flag records that the node was reset, either by the hardware reset, by a software reset strobe, or by a write of zero to the node-ID register. Only the clear-flags command removes that flag.

The CPU reads an 8-bit status word. A mask register selects which status bits may drive a registered interrupt line. The line-side logic uses a combinational ACK/NAK decision for each incoming packet, and takes the latched page number to know where the next packet goes.

Top module: `rxs_status_top`

## Requirements
- R1: After the hardware reset (`rst_n` low), the status word reads 0x90 (bit 7 receive-inhibit = 1, bit 4 power-on = 1), `rx_page` is 0, the mask is 0 and `irq` is 0.
- R2: A `cmd_enrx` pulse clears status bit 7 and latches `cmd_page` into `rx_page`, both visible after the next clock edge.
- R3: A `pkt_deposited` pulse while bit 7 is 0 sets bit 7 at the next edge. A deposit while bit 7 is already 1 has no effect on the status word or on `rx_page`.
- R4: When `cmd_enrx` and `pkt_deposited` fall in the same cycle, the command wins: bit 7 ends 0 and the new page is latched.
- R5: In any cycle with `pkt_incoming` high, `rx_ack` is 1 when bit 7 is 0 and `rx_nak` is 1 when bit 7 is 1. Both are combinational and use the bit 7 value from before any same-cycle deposit. With `pkt_incoming` low, both outputs are 0.
- R6: Status bit 4 sets on a `sw_reset` pulse or on a node-ID write (`nid_wr_en`) with data 0x00. A nonzero node-ID write leaves the status word unchanged. `sw_reset` also sets bit 7 and clears `rx_page`. It leaves the mask alone.
- R7: Only a `cmd_clrflags` pulse clears bit 4, and it does not touch bit 7. If a set cause from R6 falls in the same cycle as clear-flags, bit 4 ends 1.
- R8: `irq` is a register equal to the OR over all bits of (status AND mask). A `mask_wr_en` write loads `mask_wr_data` into the mask. `irq` follows any change of flag or mask one clock edge after the edge that made the change.
- R9: Status bits 6, 5, 3, 2, 1 and 0 always read 0, so mask bits at those positions never raise `irq`.
- R10: `sw_reset` takes priority over a same-cycle `cmd_enrx`: the status word reads 0x90 and `rx_page` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, asynchronous, active low |
| sw_reset | input | 1 | Software reset strobe |
| nid_wr_en | input | 1 | Node-ID register write strobe |
| nid_wr_data | input | 8 | Node-ID write data |
| cmd_enrx | input | 1 | Enable-receive-to-page command strobe |
| cmd_page | input | PAGE_W (2) | Target page for enable-receive |
| cmd_clrflags | input | 1 | Clear-flags command strobe |
| pkt_deposited | input | 1 | A received packet was stored in the buffer |
| pkt_incoming | input | 1 | A packet addressed to this node is arriving |
| mask_wr_en | input | 1 | Interrupt mask write strobe |
| mask_wr_data | input | 8 | Interrupt mask write data |
| status | output | 8 | Status word |
| rx_page | output | PAGE_W (2) | Latched receive page |
| irq | output | 1 | Masked, registered interrupt request |
| rx_ack | output | 1 | Accept the incoming packet |
| rx_nak | output | 1 | Refuse the incoming packet |

## Verification
Two pairs of events can land in the same cycle. A stored packet can coincide with a fresh enable-receive command, and an incoming packet can coincide with a deposit that locks the receiver. The bench drives each pair together from its vector table. It judges the first pair by the status word and page after the edge, and the second by the ACK seen before the edge. Colliding reset causes are also provoked: clear-flags together with a zero node-ID write, and software reset together with enable-receive. The bench checks that the set cause or the reset wins.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int STAT_W   = 8;
    localparam int BIT_RI   = 7;
    localparam int BIT_POR  = 4;

    typedef enum logic [1:0] {
        POR_KEEP  = 2'd0,
        POR_SET   = 2'd1,
        POR_CLEAR = 2'd2
    } por_act_e;

    function automatic logic [STAT_W-1:0] pack_status(input logic ri, input logic por);
        logic [STAT_W-1:0] w;
        w          = '0;
        w[BIT_RI]  = ri;
        w[BIT_POR] = por;
        return w;
    endfunction
endpackage

// File: rtl/rxs_flag_unit.sv
module rxs_flag_unit #(
    parameter int PAGE_W = 2,
    parameter int NID_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_reset,
    input  logic              nid_wr_en,
    input  logic [NID_W-1:0]  nid_wr_data,
    input  logic              cmd_enrx,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic              cmd_clrflags,
    input  logic              pkt_deposited,
    output logic              ri_q,
    output logic              por_q,
    output logic [PAGE_W-1:0] page_q
);
    import rxs_pkg::*;

    typedef struct packed {
        logic              ri;
        logic              por;
        logic [PAGE_W-1:0] page;
    } flag_st_t;

    flag_st_t st_q, st_d;
    por_act_e por_act;
    logic     nid_zero;

    always_comb begin
        nid_zero = nid_wr_en && (nid_wr_data == '0);
        if (sw_reset || nid_zero)
            por_act = POR_SET;
        else if (cmd_clrflags)
            por_act = POR_CLEAR;
        else
            por_act = POR_KEEP;
    end

    always_comb begin
        st_d = st_q;
        case (por_act)
            POR_SET:   st_d.por = 1'b1;
            POR_CLEAR: st_d.por = 1'b0;
            default:   st_d.por = st_q.por;
        endcase
        if (sw_reset) begin
            st_d.ri   = 1'b1;
            st_d.page = '0;
        end else if (cmd_enrx) begin
            st_d.ri   = 1'b0;
            st_d.page = cmd_page;
        end else if (pkt_deposited && !st_q.ri) begin
            st_d.ri   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ri   <= 1'b1;
            st_q.por  <= 1'b1;
            st_q.page <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ri_q   = st_q.ri;
    assign por_q  = st_q.por;
    assign page_q = st_q.page;
endmodule

// File: rtl/rxs_irq_mask.sv
module rxs_irq_mask #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_wr_en,
    input  logic [W-1:0] mask_wr_data,
    input  logic [W-1:0] status,
    output logic [W-1:0] mask_q,
    output logic         irq_q
);
    typedef struct packed {
        logic [W-1:0] mask;
        logic         irq;
    } irq_st_t;

    irq_st_t st_q, st_d;
    logic [W-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_hit
            assign hit[gi] = status[gi] & st_q.mask[gi];
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        st_d.irq = |hit;
        if (mask_wr_en)
            st_d.mask = mask_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_q = st_q.mask;
    assign irq_q  = st_q.irq;
endmodule

// File: rtl/rxs_ack_decide.sv
module rxs_ack_decide (
    input  logic pkt_incoming,
    input  logic ri_q,
    output logic rx_ack,
    output logic rx_nak
);
    always_comb begin
        rx_ack = 1'b0;
        rx_nak = 1'b0;
        if (pkt_incoming) begin
            if (ri_q) rx_nak = 1'b1;
            else      rx_ack = 1'b1;
        end
    end
endmodule

// File: rtl/rxs_status_top.sv
module rxs_status_top #(
    parameter int PAGE_W = 2,
    parameter int NID_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sw_reset,
    input  logic                      nid_wr_en,
    input  logic [NID_W-1:0]          nid_wr_data,
    input  logic                      cmd_enrx,
    input  logic [PAGE_W-1:0]         cmd_page,
    input  logic                      cmd_clrflags,
    input  logic                      pkt_deposited,
    input  logic                      pkt_incoming,
    input  logic                      mask_wr_en,
    input  logic [rxs_pkg::STAT_W-1:0] mask_wr_data,
    output logic [rxs_pkg::STAT_W-1:0] status,
    output logic [PAGE_W-1:0]         rx_page,
    output logic                      irq,
    output logic                      rx_ack,
    output logic                      rx_nak
);
    import rxs_pkg::*;

    logic              ri_q;
    logic              por_q;
    logic [STAT_W-1:0] mask_q;

    rxs_flag_unit #(.PAGE_W(PAGE_W), .NID_W(NID_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .nid_wr_en(nid_wr_en), .nid_wr_data(nid_wr_data),
        .cmd_enrx(cmd_enrx), .cmd_page(cmd_page),
        .cmd_clrflags(cmd_clrflags), .pkt_deposited(pkt_deposited),
        .ri_q(ri_q), .por_q(por_q), .page_q(rx_page)
    );

    assign status = pack_status(ri_q, por_q);

    rxs_irq_mask #(.W(STAT_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .mask_wr_en(mask_wr_en),
        .mask_wr_data(mask_wr_data), .status(status),
        .mask_q(mask_q), .irq_q(irq)
    );

    rxs_ack_decide u_ack (
        .pkt_incoming(pkt_incoming), .ri_q(ri_q),
        .rx_ack(rx_ack), .rx_nak(rx_nak)
    );
endmodule

// File: rtl/rxs_status_chk.sv
module rxs_status_chk #(
    parameter int PAGE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sw_reset,
    input logic              cmd_enrx,
    input logic [PAGE_W-1:0] cmd_page,
    input logic              cmd_clrflags,
    input logic              pkt_deposited,
    input logic              pkt_incoming,
    input logic [7:0]        status,
    input logic [7:0]        mask_q,
    input logic [PAGE_W-1:0] rx_page,
    input logic              irq,
    input logic              rx_ack,
    input logic              rx_nak
);
    assert_enrx_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_enrx && !sw_reset) |=> (!status[7] && rx_page == $past(cmd_page)));

    assert_deposit_locks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_deposited && !cmd_enrx) |=> status[7]);

    assert_nak_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_incoming && status[7]) |-> (rx_nak && !rx_ack));

    assert_idle_no_resp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_incoming |-> (!rx_ack && !rx_nak));

    assert_por_clear_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[4]) |-> $past(cmd_clrflags));

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(status) & $past(mask_q))));

    assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[6:5] == 2'b00 && status[3:0] == 4'h0));

    assert_swreset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (status[7] && status[4] && rx_page == '0));
endmodule

bind rxs_status_top rxs_status_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cmd_enrx(cmd_enrx),
    .cmd_page(cmd_page), .cmd_clrflags(cmd_clrflags),
    .pkt_deposited(pkt_deposited), .pkt_incoming(pkt_incoming),
    .status(status), .mask_q(mask_q), .rx_page(rx_page), .irq(irq),
    .rx_ack(rx_ack), .rx_nak(rx_nak)
);

// File: tb/sim_rxs_status_top.sv
`timescale 1ns/1ps
module sim_rxs_status_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_reset = 1'b0;
    logic       nid_wr_en = 1'b0;
    logic [7:0] nid_wr_data = 8'h00;
    logic       cmd_enrx = 1'b0;
    logic [1:0] cmd_page = 2'd0;
    logic       cmd_clrflags = 1'b0;
    logic       pkt_deposited = 1'b0;
    logic       pkt_incoming = 1'b0;
    logic       mask_wr_en = 1'b0;
    logic [7:0] mask_wr_data = 8'h00;
    logic [7:0] status;
    logic [1:0] rx_page;
    logic       irq, rx_ack, rx_nak;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rxs_status_top u0 (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset),
        .nid_wr_en(nid_wr_en), .nid_wr_data(nid_wr_data),
        .cmd_enrx(cmd_enrx), .cmd_page(cmd_page), .cmd_clrflags(cmd_clrflags),
        .pkt_deposited(pkt_deposited), .pkt_incoming(pkt_incoming),
        .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .status(status), .rx_page(rx_page), .irq(irq),
        .rx_ack(rx_ack), .rx_nak(rx_nak)
    );

    typedef struct packed {
        logic       enrx;
        logic [1:0] page;
        logic       dep;
        logic       inc;
        logic       clr;
        logic       nidwr;
        logic [7:0] nid;
        logic [7:0] exp_st;
        logic [1:0] exp_pg;
        logic       exp_ack;
        logic       exp_nak;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h80, 2'd0, 1'b0, 1'b0}, // R7 clear power-on
        '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h80, 2'd0, 1'b0, 1'b1}, // R5 nak while locked
        '{1'b1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 2'd2, 1'b0, 1'b0}, // R2 enable page 2
        '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 2'd2, 1'b1, 1'b0}, // R5 ack when open
        '{1'b0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h80, 2'd2, 1'b1, 1'b0}, // R5 R3 ack uses old flag
        '{1'b0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 2'd2, 1'b0, 1'b0}, // R3 deposit while locked
        '{1'b1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 2'd1, 1'b0, 1'b0}, // R4 command beats deposit
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 8'h00, 2'd1, 1'b0, 1'b0}, // R6 nonzero node id
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h10, 2'd1, 1'b0, 1'b0}, // R6 zero node id
        '{1'b0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h10, 2'd1, 1'b1, 1'b0}, // R5 ack with por set
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h10, 2'd1, 1'b0, 1'b0}, // R7 set beats clear
        '{1'b0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 2'd1, 1'b0, 1'b0}, // R7 clear leaves ri
        '{1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 2'd1, 1'b0, 1'b0}  // R3 deposit locks
    };

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle_all();
        sw_reset = 0; nid_wr_en = 0; cmd_enrx = 0; cmd_clrflags = 0;
        pkt_deposited = 0; pkt_incoming = 0; mask_wr_en = 0;
    endtask

    // drive at negedge, sample combinational before the edge, registered after
    task automatic tick();
        @(posedge clk); #1;
        idle_all();
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status, 8'h90);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", status, 8'h90);
        chk("R1 page after reset", {6'd0, rx_page}, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            cmd_enrx = VECS[i].enrx; cmd_page = VECS[i].page;
            pkt_deposited = VECS[i].dep; pkt_incoming = VECS[i].inc;
            cmd_clrflags = VECS[i].clr; nid_wr_en = VECS[i].nidwr;
            nid_wr_data = VECS[i].nid;
            #1;
            chk($sformatf("R5 ack vec %0d", i), {7'd0, rx_ack}, {7'd0, VECS[i].exp_ack});
            chk($sformatf("R5 nak vec %0d", i), {7'd0, rx_nak}, {7'd0, VECS[i].exp_nak});
            @(posedge clk); #1;
            idle_all();
            chk($sformatf("R2 R3 R4 R6 R7 status vec %0d", i), status, VECS[i].exp_st);
            chk($sformatf("R2 R4 page vec %0d", i), {6'd0, rx_page}, {6'd0, VECS[i].exp_pg});
            @(negedge clk);
        end

        // status now 0x80: interrupt masking, R8
        mask_wr_en = 1; mask_wr_data = 8'h80;
        @(posedge clk); #1; idle_all();
        chk("R8 irq one edge after mask write still 0", {7'd0, irq}, 8'h00);
        @(posedge clk); #1;
        chk("R8 irq rises after mask", {7'd0, irq}, 8'h01);
        @(negedge clk);
        cmd_enrx = 1; cmd_page = 2'd3;
        @(posedge clk); #1; idle_all();
        chk("R8 irq holds on flag-clear edge", {7'd0, irq}, 8'h01);
        @(posedge clk); #1;
        chk("R8 irq falls after flag clears", {7'd0, irq}, 8'h00);
        @(negedge clk);

        // R9: mask only the undefined bits
        mask_wr_en = 1; mask_wr_data = 8'h6F;
        tick();
        pkt_deposited = 1;
        tick();
        repeat (2) @(posedge clk); #1;
        chk("R9 undefined bits stay 0", status & 8'h6F, 8'h00);
        chk("R9 irq stays 0 with undefined-bit mask", {7'd0, irq}, 8'h00);
        @(negedge clk);

        // R6: software reset, mask kept
        mask_wr_en = 1; mask_wr_data = 8'h10;
        tick();
        sw_reset = 1;
        @(posedge clk); #1; idle_all();
        chk("R6 sw reset status", status, 8'h90);
        chk("R6 sw reset page", {6'd0, rx_page}, 8'h00);
        @(posedge clk); #1;
        chk("R6 R8 mask kept, por raises irq", {7'd0, irq}, 8'h01);
        @(negedge clk);

        // R10: sw reset beats enable-receive
        cmd_enrx = 1; cmd_page = 2'd2;
        tick();
        chk("R10 setup enrx", status, 8'h10);
        sw_reset = 1; cmd_enrx = 1; cmd_page = 2'd1;
        @(posedge clk); #1; idle_all();
        chk("R10 status", status, 8'h90);
        chk("R10 page", {6'd0, rx_page}, 8'h00);
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule